// File: doc/BRIEF.md
# Cross-paired odd-even sorted-list merger

This block takes two ascending lists of equal length M (a power of two, four by default), A and B, and returns their union as one ascending list of 2M unsigned keys. Each list is first cut into its even-position keys (0, 2, ..., M-2) and its odd-position keys (1, 3, ..., M-1). Two independent sub-merges run side by side. The first combines the even part of A with the odd part of B into a list E. The second combines the even part of B with the odd part of A into a list O. The two results are interleaved as E0, O0, E1, O1, ... and a single rank of compare-exchange cells, acting on the position pairs (0,1), (2,3) and so on, places the smaller key of each pair in the lower position. For A = 2,3,4,8 and B = 1,5,6,7 the sub-merges give E = 2,4,5,7 and O = 1,3,6,8, and the output is 1 through 8.

Each sub-merge is a bitonic half-cleaner cascade of log2(M) ranks, and every rank, including the final pair rank, is registered. Both lists are presented in parallel with a valid/ready handshake. The merged list leaves with a valid flag after a fixed number of clock cycles. When the consumer withholds ready, the whole pipeline freezes.

Top module: `xm_cross_merge`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `out_valid` is 0.
- R2: Key j of each port vector occupies bits [j*W +: W], with key 0 the smallest. For any two ascending input lists, `out_keys` is the ascending ordering of all 2M input keys.
- R3: Whenever `out_valid` is 1, `out_keys` is nondecreasing from key 0 to key 2M-1.
- R4: With `out_ready` held high, a set accepted at a rising edge appears with `out_valid` = 1 exactly LAT = log2(M)+1 rising edges later, and not earlier.
- R5: Equal keys are neither lost nor duplicated. Each key value appears in the output as many times as in the two inputs together, and every registered rank preserves the sum of its keys.
- R6: While `out_ready` is 0, `in_ready` is 0, nothing advances, and a valid output keeps `out_valid` and `out_keys` unchanged.
- R7: `in_ready` follows `out_ready`. A set is accepted at a rising edge where `in_valid` and `in_ready` are both 1. Sets accepted on consecutive edges leave on consecutive cycles in the same order.
- R8: Keys compare as unsigned over the full W-bit range, so 0 and 2^W-1 sort correctly next to each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Both input lists are present |
| in_ready | output | 1 | The block accepts a set at this edge |
| in_a | input | M*W | List A, ascending, key j at bits [j*W +: W] |
| in_b | input | M*W | List B, ascending, key j at bits [j*W +: W] |
| out_valid | output | 1 | `out_keys` holds a merged list |
| out_ready | input | 1 | The consumer takes the output; low stalls the pipeline |
| out_keys | output | 2*M*W | Merged list, ascending, key j at bits [j*W +: W] |

## Verification
Two properties are checked on every cycle. The output order holds whenever the output is valid, and each registered rank keeps the key sum it loaded, which catches a cell that drops or copies a key. A stalled output must also hold both its valid flag and its data. Properties cannot show that the output is the right permutation of the inputs, that the latency is exact, that the cross pairing works on interleaved, disjoint and duplicate-heavy lists, or that back-to-back sets stay in order. The directed scenarios cover these by comparing against a reference sort kept in the bench.

// File: rtl/xm_pkg.sv
`timescale 1ns/1ps
package xm_pkg;
  // Pipeline depth: log2(M) half-cleaner ranks plus the pair rank.
  function automatic int unsigned xm_depth(input int unsigned m);
    return $clog2(m) + 1;
  endfunction
endpackage

// File: rtl/xm_cx.sv
`timescale 1ns/1ps
// Unsigned compare-exchange: smaller key to lo, larger to hi.
module xm_cx #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  output logic [W-1:0] lo,
  output logic [W-1:0] hi
);
  logic swap;
  assign swap = x > y;
  assign lo   = swap ? y : x;
  assign hi   = swap ? x : y;
endmodule

// File: rtl/xm_half_rank.sv
`timescale 1ns/1ps
// One registered half-cleaner rank applied to two independent M-lane blocks.
module xm_half_rank #(
  parameter int W = 8,
  parameter int M = 4,
  parameter int D = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             d_valid,
  input  logic [2*M*W-1:0] d_keys,
  output logic             q_valid,
  output logic [2*M*W-1:0] q_keys
);
  localparam int N  = 2 * M;
  localparam int SW = W + $clog2(N) + 1;

  logic [W-1:0] nx [N];

  for (genvar i = 0; i < N; i++) begin : g_lane
    if (((i % M) & D) == 0) begin : g_pair
      xm_cx #(.W(W)) u_cx (
        .x (d_keys[i*W +: W]),
        .y (d_keys[(i+D)*W +: W]),
        .lo(nx[i]),
        .hi(nx[i+D])
      );
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     q_valid <= 1'b0;
    else if (en) q_valid <= d_valid;
  end

  always_ff @(posedge clk) begin
    if (en)
      for (int i = 0; i < N; i++) q_keys[i*W +: W] <= nx[i];
  end

  logic [SW-1:0] d_sum, q_sum;
  always_comb begin
    d_sum = '0;
    q_sum = '0;
    for (int i = 0; i < N; i++) begin
      d_sum = d_sum + SW'(d_keys[i*W +: W]);
      q_sum = q_sum + SW'(q_keys[i*W +: W]);
    end
  end

  // R5: a loaded rank holds exactly the keys it was given
  a_r5_rank_sum_kept: assert property (@(posedge clk) disable iff (rst)
    (q_valid && $past(en)) |-> (q_sum == $past(d_sum)));
endmodule

// File: rtl/xm_pair_rank.sv
`timescale 1ns/1ps
// Registered final rank: interleave E (lanes 0..M-1) with O (lanes M..2M-1)
// and compare-exchange the output pairs (2i, 2i+1).
module xm_pair_rank #(
  parameter int W = 8,
  parameter int M = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             d_valid,
  input  logic [2*M*W-1:0] d_keys,
  output logic             q_valid,
  output logic [2*M*W-1:0] q_keys
);
  localparam int N  = 2 * M;
  localparam int SW = W + $clog2(N) + 1;

  logic [W-1:0] nx [N];

  for (genvar i = 0; i < M; i++) begin : g_pair
    xm_cx #(.W(W)) u_cx (
      .x (d_keys[i*W +: W]),
      .y (d_keys[(M+i)*W +: W]),
      .lo(nx[2*i]),
      .hi(nx[2*i+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst)     q_valid <= 1'b0;
    else if (en) q_valid <= d_valid;
  end

  always_ff @(posedge clk) begin
    if (en)
      for (int i = 0; i < N; i++) q_keys[i*W +: W] <= nx[i];
  end

  logic [SW-1:0] d_sum, q_sum;
  always_comb begin
    d_sum = '0;
    q_sum = '0;
    for (int i = 0; i < N; i++) begin
      d_sum = d_sum + SW'(d_keys[i*W +: W]);
      q_sum = q_sum + SW'(q_keys[i*W +: W]);
    end
  end

  // R5: the pair rank neither loses nor copies a key
  a_r5_pair_sum_kept: assert property (@(posedge clk) disable iff (rst)
    (q_valid && $past(en)) |-> (q_sum == $past(d_sum)));
endmodule

// File: rtl/xm_cross_merge.sv
`timescale 1ns/1ps
// Two sorted M-key lists in, one sorted 2M-key list out. M must be a power of two, >= 2.
module xm_cross_merge
  import xm_pkg::*;
#(
  parameter int W = 8,
  parameter int M = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [M*W-1:0]   in_a,
  input  logic [M*W-1:0]   in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [2*M*W-1:0] out_keys
);
  localparam int H   = M / 2;
  localparam int K   = $clog2(M);
  localparam int N   = 2 * M;
  localparam int LAT = xm_depth(M);

  logic             en;
  logic [N*W-1:0]   lanes0;
  logic [N*W-1:0]   st_keys [K+1];
  logic             st_vld  [K+1];

  assign en       = out_ready;
  assign in_ready = out_ready;

  // Block 0 builds E from Even(A) ascending then Odd(B) descending (bitonic);
  // block 1 builds O from Even(B) ascending then Odd(A) descending.
  always_comb begin
    for (int j = 0; j < H; j++) begin
      lanes0[j*W +: W]         = in_a[(2*j)*W +: W];
      lanes0[(H+j)*W +: W]     = in_b[(2*(H-1-j)+1)*W +: W];
      lanes0[(M+j)*W +: W]     = in_b[(2*j)*W +: W];
      lanes0[(M+H+j)*W +: W]   = in_a[(2*(H-1-j)+1)*W +: W];
    end
  end

  assign st_keys[0] = lanes0;
  assign st_vld[0]  = in_valid;

  for (genvar s = 0; s < K; s++) begin : g_rank
    xm_half_rank #(.W(W), .M(M), .D(M >> (s + 1))) u_rank (
      .clk    (clk),
      .rst    (rst),
      .en     (en),
      .d_valid(st_vld[s]),
      .d_keys (st_keys[s]),
      .q_valid(st_vld[s+1]),
      .q_keys (st_keys[s+1])
    );
  end

  xm_pair_rank #(.W(W), .M(M)) u_pair (
    .clk    (clk),
    .rst    (rst),
    .en     (en),
    .d_valid(st_vld[K]),
    .d_keys (st_keys[K]),
    .q_valid(out_valid),
    .q_keys (out_keys)
  );

  logic sorted_ok;
  always_comb begin
    sorted_ok = 1'b1;
    for (int i = 0; i + 1 < N; i++)
      if (out_keys[i*W +: W] > out_keys[(i+1)*W +: W]) sorted_ok = 1'b0;
  end

  // R3: a valid output is in ascending order
  a_r3_output_sorted: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> sorted_ok);

  // R6: a stalled valid output stays valid
  a_r6_hold_valid: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> out_valid);

  // R6: a stalled valid output keeps its keys
  a_r6_hold_keys: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> $stable(out_keys));

  initial begin
    if (LAT != K + 1) $error("depth mismatch");
  end
endmodule

// File: tb/xm_cross_merge_bench.sv
`timescale 1ns/1ps
module xm_cross_merge_bench;
  localparam int W   = 8;
  localparam int M   = 4;
  localparam int N   = 2 * M;
  localparam int LAT = $clog2(M) + 1;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           in_valid = 1'b0;
  logic           in_ready;
  logic [M*W-1:0] in_a = '0;
  logic [M*W-1:0] in_b = '0;
  logic           out_valid;
  logic           out_ready = 1'b1;
  logic [N*W-1:0] out_keys;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  done     = 1'b0;

  always #2.5 clk = ~clk;

  xm_cross_merge #(.W(W), .M(M)) u_xm_cross_merge (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_keys(out_keys)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic load(input logic [W-1:0] a[M], input logic [W-1:0] b[M]);
    for (int j = 0; j < M; j++) begin
      in_a[j*W +: W] = a[j];
      in_b[j*W +: W] = b[j];
    end
  endtask

  function automatic void ref_sort(input logic [W-1:0] a[M], input logic [W-1:0] b[M],
                                   output logic [W-1:0] r[N]);
    for (int j = 0; j < M; j++) begin
      r[j] = a[j];
      r[M+j] = b[j];
    end
    for (int i = 1; i < N; i++)
      for (int j = i; j > 0 && r[j-1] > r[j]; j--) begin
        logic [W-1:0] t;
        t = r[j]; r[j] = r[j-1]; r[j-1] = t;
      end
  endfunction

  task automatic cmp_out(input logic [W-1:0] r[N], input string req);
    chk(out_valid === 1'b1, req, "out_valid", int'(out_valid), 1);
    for (int i = 0; i < N; i++)
      chk(out_keys[i*W +: W] === r[i], req, $sformatf("key %0d", i),
          int'(out_keys[i*W +: W]), int'(r[i]));
  endtask

  // One set through the pipe, checking exact latency and contents.
  task automatic run_one(input logic [W-1:0] a[M], input logic [W-1:0] b[M],
                         input string req);
    logic [W-1:0] r[N];
    ref_sort(a, b, r);
    @(negedge clk);
    load(a, b);
    in_valid  = 1'b1;
    out_ready = 1'b1;
    for (int c = 1; c <= LAT; c++) begin
      @(negedge clk);
      if (c == 1) in_valid = 1'b0;
      if (c < LAT) chk(out_valid === 1'b0, "R4", "early out_valid", int'(out_valid), 0);
    end
    cmp_out(r, req);
  endtask

  task automatic t_reset();
    repeat (3) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_example();
    run_one('{8'd2, 8'd3, 8'd4, 8'd8}, '{8'd1, 8'd5, 8'd6, 8'd7}, "R2");
  endtask

  task automatic t_patterns();
    run_one('{8'd1, 8'd2, 8'd3, 8'd4}, '{8'd5, 8'd6, 8'd7, 8'd8}, "R2");   // disjoint, A low
    run_one('{8'd50, 8'd60, 8'd70, 8'd80}, '{8'd1, 8'd2, 8'd3, 8'd4}, "R2"); // disjoint, A high
    run_one('{8'd1, 8'd3, 8'd5, 8'd7}, '{8'd2, 8'd4, 8'd6, 8'd8}, "R3");   // fully interleaved
    run_one('{8'd10, 8'd11, 8'd40, 8'd41}, '{8'd20, 8'd21, 8'd30, 8'd31}, "R3");
  endtask

  task automatic t_duplicates();
    run_one('{8'd5, 8'd5, 8'd5, 8'd5}, '{8'd5, 8'd5, 8'd5, 8'd5}, "R5");
    run_one('{8'd3, 8'd3, 8'd9, 8'd9}, '{8'd3, 8'd7, 8'd7, 8'd9}, "R5");
  endtask

  task automatic t_extremes();
    run_one('{8'd0, 8'd0, 8'd255, 8'd255}, '{8'd0, 8'd128, 8'd255, 8'd255}, "R8");
    run_one('{8'd127, 8'd128, 8'd254, 8'd255}, '{8'd0, 8'd1, 8'd128, 8'd255}, "R8");
  endtask

  task automatic t_stall();
    logic [W-1:0] a[M] = '{8'd4, 8'd9, 8'd12, 8'd30};
    logic [W-1:0] b[M] = '{8'd2, 8'd9, 8'd15, 8'd16};
    logic [W-1:0] r[N];
    ref_sort(a, b, r);
    @(negedge clk);
    load(a, b);
    in_valid  = 1'b1;
    out_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(in_ready === 1'b0, "R6", "in_ready while stalled", int'(in_ready), 0);
      chk(out_valid === 1'b0, "R6", "out_valid, nothing taken", int'(out_valid), 0);
    end
    out_ready = 1'b1;
    @(negedge clk);                 // accepted at this edge
    in_valid  = 1'b0;
    out_ready = 1'b0;
    repeat (4) begin
      @(negedge clk);
      chk(out_valid === 1'b0, "R6", "out_valid mid-pipe stall", int'(out_valid), 0);
    end
    out_ready = 1'b1;
    repeat (LAT - 1) @(negedge clk);
    cmp_out(r, "R6");
    out_ready = 1'b0;
    repeat (3) begin
      @(negedge clk);
      cmp_out(r, "R6");
    end
    out_ready = 1'b1;
    @(negedge clk);
    chk(out_valid === 1'b0, "R7", "out_valid after drain", int'(out_valid), 0);
  endtask

  task automatic t_stream();
    logic [W-1:0] a0[M] = '{8'd1, 8'd20, 8'd30, 8'd40};
    logic [W-1:0] b0[M] = '{8'd2, 8'd3, 8'd4, 8'd50};
    logic [W-1:0] a1[M] = '{8'd9, 8'd9, 8'd9, 8'd9};
    logic [W-1:0] b1[M] = '{8'd0, 8'd10, 8'd11, 8'd12};
    logic [W-1:0] a2[M] = '{8'd100, 8'd101, 8'd102, 8'd200};
    logic [W-1:0] b2[M] = '{8'd99, 8'd150, 8'd151, 8'd152};
    logic [W-1:0] r0[N], r1[N], r2[N];
    ref_sort(a0, b0, r0);
    ref_sort(a1, b1, r1);
    ref_sort(a2, b2, r2);
    @(negedge clk);
    out_ready = 1'b1;
    chk(in_ready === 1'b1, "R7", "in_ready follows out_ready", int'(in_ready), 1);
    load(a0, b0); in_valid = 1'b1;
    @(negedge clk); load(a1, b1);
    @(negedge clk); load(a2, b2);
    @(negedge clk); in_valid = 1'b0;  // three edges taken
    repeat (LAT - 3 > 0 ? LAT - 3 : 0) @(negedge clk);
    if (LAT >= 3) begin
      cmp_out(r0, "R7");
      @(negedge clk); cmp_out(r1, "R7");
      @(negedge clk); cmp_out(r2, "R7");
    end
    @(negedge clk);
    chk(out_valid === 1'b0, "R7", "out_valid after stream", int'(out_valid), 0);
  endtask

  initial begin
    t_reset();
    t_example();
    t_patterns();
    t_duplicates();
    t_extremes();
    t_stall();
    t_stream();
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fails);
      $finish;
    end
  end
endmodule